// File: doc/BRIEF.md
# Quad SPI flash read master

This block sits on the host side of a serial NOR flash and fetches bytes from it. A client hands it a read request (a 24-bit byte address and a byte count) on a valid/ready pair. The block generates the serial clock and the active-low chip select, drives the four data lanes through separate per-lane output enables, and returns each received byte as a one-cycle pulse on a valid-qualified output.

A configuration input chooses the lane format: one lane, four lanes with one transfer per clock, or four lanes with a transfer on each clock edge. A second input asks for continuous read mode. In that mode the flash stays armed after a read, and the next read leaves out the command byte and starts with the address. The block remembers whether the flash is armed and in which format. It sends the mode byte that disarms the flash when the client drops continuous mode or asks for a different format.

After reset the block wakes the flash by itself and only then accepts requests.

Top module: `qspi_read_master`

## Requirements
- R1: During reset and right after it, `csN` is 1, `sclk` is 0 and `reqReady` is 0. Before the first request is accepted, the block runs two separate chip-select windows, each carrying one single-lane command: FFh first, then ABh. Reset also clears the armed state, so the next read sends its command byte.
- R2: The format code on `cfgMode` is 0 for single lane, 1 for quad with one transfer per clock and 2 for quad on both edges; code 3 acts as single lane. In single-lane format the block sends 03h and then 24 address bits, MSB first on io0 with only `ioOe[0]` set. It captures data bits from io1 on each rising `sclk` edge, MSB first.
- R3: The quad one-transfer-per-clock format sends command EBh on io0 alone. It then sends the address and the mode byte with all four enables set, high nibble before low nibble, one nibble per clock. Lane k carries bit k+4 and then bit k of each byte.
- R4: The quad both-edges format sends command EDh on io0 alone. Each address and mode byte then takes one `sclk` period: the high nibble is stable before the rising edge and the low nibble is driven while `sclk` is high.
- R5: In both quad formats, all four output enables go low right after the mode byte. One dummy `sclk` period follows, and data starts on the next period.
- R6: In the both-edges format, each received byte takes its high nibble from the lanes at the rising edge and its low nibble at the falling edge.
- R7: With `cfgCont` set, a quad format that matches the armed format (or any quad format when nothing is armed) sends mode byte A5h and arms the flash. The next request then sends no command byte and starts with the address.
- R8: A request made while armed is carried out in the armed format without a command byte. If `cfgCont` is clear, or `cfgMode` names a different format, this request sends mode byte FFh and disarms, and the request after it sends its command byte in the format `cfgMode` names.
- R9: A request for N bytes (N at least 1) yields exactly N one-cycle `rdValid` pulses. The bytes come in ascending address order, starting at the requested address.
- R10: `sclk` has a period of exactly CLK_DIV system clocks (CLK_DIV even, at least 2) and is low whenever `csN` is high. Between chip-select windows, `csN` stays high for at least CLK_DIV system clocks.
- R11: `reqReady` is high only while the block is idle with `csN` high. It goes low in the cycle after a request is accepted and stays low until `csN` has risen after the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 24 | Start byte address |
| reqCount | input | CNT_W | Number of bytes to read, at least 1 |
| cfgMode | input | 2 | Lane format code |
| cfgCont | input | 1 | Ask for continuous read mode |
| sclk | output | 1 | Serial clock to the flash |
| csN | output | 1 | Active-low chip select |
| ioOut | output | 4 | Values driven onto the four data lanes |
| ioOe | output | 4 | Per-lane output enables |
| ioIn | input | 4 | Values sampled from the four data lanes |
| rdValid | output | 1 | Received byte valid, one cycle |
| rdData | output | 8 | Received byte |

## Verification
The assertions assume that `reqCount` is never zero. They also assume that `reqAddr`, `reqCount`, `cfgMode` and `cfgCont` are stable in the accept cycle, and that CLK_DIV is even. The stimulus meets these by presenting every request for exactly one cycle while `reqReady` is high, with counts from 1 to 5 and the default divider. The flash model in the bench drives `ioIn` only in the data phase, half a system clock after each `sclk` edge, so every value is settled well before the edge that captures it.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;

  typedef enum logic [1:0] {
    MODE_SPI  = 2'd0,
    MODE_QSDR = 2'd1,
    MODE_QDDR = 2'd2
  } laneMode_e;

  typedef enum logic [1:0] {
    ST_GAP,
    ST_IDLE,
    ST_RUN
  } ctrlState_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA
  } phase_e;

  typedef struct packed {
    logic       accept;
    logic       loadCmd;
    logic [7:0] cmdByte;
    logic       loadAddr;
    logic [7:0] modeByte;
    logic       shift1;
    logic       shift4;
    logic       wideOut;
    logic       capBit;
    logic       capNib;
    logic       emit;
    logic       ddrMode;
  } dpStrobe_t;

  localparam logic [7:0] MODE_KEEP = 8'hA5;
  localparam logic [7:0] MODE_EXIT = 8'hFF;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_WAKE  = 8'hAB;

  function automatic laneMode_e normMode(input logic [1:0] code);
    case (code)
      2'd1:    return MODE_QSDR;
      2'd2:    return MODE_QDDR;
      default: return MODE_SPI;
    endcase
  endfunction

  function automatic logic [7:0] cmdFor(input laneMode_e m);
    case (m)
      MODE_QSDR: return 8'hEB;
      MODE_QDDR: return 8'hED;
      default:   return 8'h03;
    endcase
  endfunction

  // slots (serial clock periods) minus one for address plus mode byte
  function automatic logic [4:0] addrLast(input laneMode_e m);
    case (m)
      MODE_QSDR: return 5'd7;
      MODE_QDDR: return 5'd3;
      default:   return 5'd23;
    endcase
  endfunction

  // slots minus one per received byte
  function automatic logic [4:0] byteLast(input laneMode_e m);
    case (m)
      MODE_QSDR: return 5'd1;
      MODE_QDDR: return 5'd0;
      default:   return 5'd7;
    endcase
  endfunction

endpackage

// File: rtl/qspi_rd_ctrl.sv
module qspi_rd_ctrl
  import qspi_rd_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [1:0]       cfgMode,
  input  logic             cfgCont,
  output logic             sclk,
  output logic             csN,
  output logic [3:0]       ioOe,
  output dpStrobe_t        stb
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int HC_W  = $clog2(HALF + 1);
  localparam int GAP_W = $clog2(CLK_DIV + 1);

  ctrlState_e       state;
  phase_e           phase;
  logic [HC_W-1:0]  halfCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [4:0]       slotCnt;
  logic [CNT_W-1:0] byteCnt;
  laneMode_e        runMode, armedMode, cfgNorm, newMode;
  logic             sclkR, csNR, armed, isBoot;
  logic [1:0]       bootLeft;
  logic [7:0]       modeReg, modeNext;
  logic             halfTick, riseEv, fallEv, lastSlot, accept, gapDone, startBoot, wantCont;

  assign halfTick  = (halfCnt == HC_W'(HALF - 1));
  assign riseEv    = (state == ST_RUN) && halfTick && !sclkR;
  assign fallEv    = (state == ST_RUN) && halfTick && sclkR;
  assign lastSlot  = (slotCnt == 5'd0);
  assign accept    = (state == ST_IDLE) && reqValid;
  assign gapDone   = (state == ST_GAP) && (gapCnt == GAP_W'(CLK_DIV - 1));
  assign startBoot = gapDone && (bootLeft != 2'd0);
  assign cfgNorm   = normMode(cfgMode);
  assign newMode   = armed ? armedMode : cfgNorm;
  assign wantCont  = cfgCont && (cfgNorm != MODE_SPI) && (cfgNorm == newMode);
  assign modeNext  = wantCont ? MODE_KEEP : MODE_EXIT;

  assign reqReady = (state == ST_IDLE);
  assign sclk     = sclkR;
  assign csN      = csNR;

  always_comb begin
    ioOe = 4'b0000;
    if (state == ST_RUN) begin
      if (phase == PH_CMD || (phase == PH_ADDR && runMode == MODE_SPI)) ioOe = 4'b0001;
      else if (phase == PH_ADDR) ioOe = 4'b1111;
    end
  end

  always_comb begin
    stb          = '0;
    stb.accept   = accept;
    stb.loadCmd  = startBoot || (accept && !armed);
    stb.cmdByte  = startBoot ? ((bootLeft == 2'd2) ? CMD_RESET : CMD_WAKE) : cmdFor(newMode);
    stb.loadAddr = (accept && armed) || (fallEv && phase == PH_CMD && lastSlot && !isBoot);
    stb.modeByte = accept ? modeNext : modeReg;
    stb.shift1   = fallEv && (phase == PH_CMD || (phase == PH_ADDR && runMode == MODE_SPI));
    stb.shift4   = (phase == PH_ADDR) && (runMode != MODE_SPI) &&
                   (fallEv || (riseEv && runMode == MODE_QDDR));
    stb.wideOut  = (phase == PH_ADDR) && (runMode != MODE_SPI);
    stb.capBit   = riseEv && (phase == PH_DATA) && (runMode == MODE_SPI);
    stb.capNib   = riseEv && (phase == PH_DATA) && (runMode != MODE_SPI);
    stb.emit     = fallEv && (phase == PH_DATA) && lastSlot;
    stb.ddrMode  = (runMode == MODE_QDDR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_GAP;
      phase     <= PH_CMD;
      halfCnt   <= '0;
      gapCnt    <= '0;
      slotCnt   <= '0;
      byteCnt   <= '0;
      runMode   <= MODE_SPI;
      armedMode <= MODE_SPI;
      sclkR     <= 1'b0;
      csNR      <= 1'b1;
      armed     <= 1'b0;
      isBoot    <= 1'b0;
      bootLeft  <= 2'd2;
      modeReg   <= MODE_EXIT;
    end else begin
      case (state)
        ST_GAP: begin
          gapCnt <= gapCnt + 1'b1;
          if (gapDone) begin
            gapCnt <= '0;
            if (bootLeft != 2'd0) begin
              state    <= ST_RUN;
              csNR     <= 1'b0;
              halfCnt  <= '0;
              phase    <= PH_CMD;
              slotCnt  <= 5'd7;
              isBoot   <= 1'b1;
              runMode  <= MODE_SPI;
              bootLeft <= bootLeft - 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_IDLE: begin
          if (reqValid) begin
            state     <= ST_RUN;
            csNR      <= 1'b0;
            halfCnt   <= '0;
            runMode   <= newMode;
            modeReg   <= modeNext;
            byteCnt   <= reqCount - 1'b1;
            isBoot    <= 1'b0;
            armed     <= wantCont;
            armedMode <= newMode;
            if (armed) begin
              phase   <= PH_ADDR;
              slotCnt <= addrLast(newMode);
            end else begin
              phase   <= PH_CMD;
              slotCnt <= 5'd7;
            end
          end
        end
        default: begin
          halfCnt <= halfTick ? '0 : halfCnt + 1'b1;
          if (halfTick) sclkR <= !sclkR;
          if (fallEv) begin
            if (!lastSlot) begin
              slotCnt <= slotCnt - 1'b1;
            end else begin
              case (phase)
                PH_CMD: begin
                  if (isBoot) begin
                    state <= ST_GAP;
                    csNR  <= 1'b1;
                  end else begin
                    phase   <= PH_ADDR;
                    slotCnt <= addrLast(runMode);
                  end
                end
                PH_ADDR: begin
                  phase   <= (runMode == MODE_SPI) ? PH_DATA : PH_DUMMY;
                  slotCnt <= (runMode == MODE_SPI) ? byteLast(MODE_SPI) : 5'd0;
                end
                PH_DUMMY: begin
                  phase   <= PH_DATA;
                  slotCnt <= byteLast(runMode);
                end
                default: begin
                  if (byteCnt == '0) begin
                    state <= ST_GAP;
                    csNR  <= 1'b1;
                  end else begin
                    byteCnt <= byteCnt - 1'b1;
                    slotCnt <= byteLast(runMode);
                  end
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  p_ready_cs_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN);
  p_sclk_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  p_cs_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN);
  p_armed_quad_r7: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (armedMode != MODE_SPI));

endmodule

// File: rtl/qspi_rd_dp.sv
module qspi_rd_dp
  import qspi_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   stb,
  input  logic [23:0] reqAddr,
  input  logic [3:0]  ioIn,
  output logic [3:0]  ioOut,
  output logic        rdValid,
  output logic [7:0]  rdData
);
  logic [23:0] addrReg;
  logic [31:0] txReg;
  logic [7:0]  rxReg;

  assign ioOut = stb.wideOut ? txReg[31:28] : {3'b000, txReg[31]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      txReg   <= '0;
      rxReg   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (stb.accept) addrReg <= reqAddr;
      if (stb.loadCmd)       txReg <= {stb.cmdByte, 24'h0};
      else if (stb.loadAddr) txReg <= {(stb.accept ? reqAddr : addrReg), stb.modeByte};
      else if (stb.shift1)   txReg <= {txReg[30:0], 1'b0};
      else if (stb.shift4)   txReg <= {txReg[27:0], 4'h0};
      if (stb.capBit)      rxReg <= {rxReg[6:0], ioIn[1]};
      else if (stb.capNib) rxReg <= {rxReg[3:0], ioIn};
      rdValid <= stb.emit;
      if (stb.emit) rdData <= stb.ddrMode ? {rxReg[3:0], ioIn} : rxReg;
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/qspi_read_master.sv
module qspi_read_master
  import qspi_rd_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [23:0]      reqAddr,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [1:0]       cfgMode,
  input  logic             cfgCont,
  output logic             sclk,
  output logic             csN,
  output logic [3:0]       ioOut,
  output logic [3:0]       ioOe,
  input  logic [3:0]       ioIn,
  output logic             rdValid,
  output logic [7:0]       rdData
);
  dpStrobe_t stb;

  qspi_rd_ctrl #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCount(reqCount), .cfgMode(cfgMode), .cfgCont(cfgCont),
    .sclk(sclk), .csN(csN), .ioOe(ioOe), .stb(stb)
  );

  qspi_rd_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .ioIn(ioIn),
    .ioOut(ioOut), .rdValid(rdValid), .rdData(rdData)
  );

  p_lanes_free_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (ioOe == 4'b0000));

endmodule

// File: tb/qspi_read_master_bench.sv
module qspi_read_master_bench;
  localparam int CLK_DIV = 4;

  typedef struct packed {
    logic [1:0]  mode;
    logic        cont;
    logic [23:0] addr;
    logic [3:0]  count;
    logic [1:0]  fmt;
    logic        expCmd;
    logic [7:0]  expMode;
  } vec_t;

  localparam vec_t VEC [0:11] = '{
    '{2'd0, 1'b0, 24'h000100, 4'd4, 2'd0, 1'b1, 8'h00},
    '{2'd1, 1'b0, 24'h100000, 4'd5, 2'd1, 1'b1, 8'hFF},
    '{2'd2, 1'b0, 24'h0ABCDE, 4'd3, 2'd2, 1'b1, 8'hFF},
    '{2'd1, 1'b1, 24'h000010, 4'd4, 2'd1, 1'b1, 8'hA5},
    '{2'd1, 1'b1, 24'h123456, 4'd2, 2'd1, 1'b0, 8'hA5},
    '{2'd1, 1'b0, 24'h000FFE, 4'd4, 2'd1, 1'b0, 8'hFF},
    '{2'd1, 1'b0, 24'h000020, 4'd1, 2'd1, 1'b1, 8'hFF},
    '{2'd2, 1'b1, 24'h000300, 4'd4, 2'd2, 1'b1, 8'hA5},
    '{2'd1, 1'b1, 24'h000400, 4'd2, 2'd2, 1'b0, 8'hFF},
    '{2'd1, 1'b1, 24'h000500, 4'd2, 2'd1, 1'b1, 8'hA5},
    '{2'd0, 1'b1, 24'h000600, 4'd2, 2'd1, 1'b0, 8'hFF},
    '{2'd3, 1'b1, 24'h000700, 4'd3, 2'd0, 1'b1, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqCount = '0;
  logic [1:0]  cfgMode = '0;
  logic        cfgCont = 1'b0;
  logic        sclk, csN, rdValid;
  logic [3:0]  ioOut, ioOe;
  logic [3:0]  ioIn = 4'h0;
  logic [7:0]  rdData;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = !clk;

  qspi_read_master #(.CLK_DIV(CLK_DIV), .CNT_W(16)) u_qspi_read_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqCount(reqCount), .cfgMode(cfgMode), .cfgCont(cfgCont),
    .sclk(sclk), .csN(csN), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn),
    .rdValid(rdValid), .rdData(rdData)
  );

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h3C;
  endfunction

  function automatic int dOf(input int fmt, input bit cmd);
    int n = cmd ? 8 : 0;
    if (fmt == 0) return n + 24;
    if (fmt == 1) return n + 9;
    return n + 5;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // flash model: observes lanes at the falling system clock, drives data half a cycle after sclk edges
  int fmtMode = 0;
  bit fmtCmd = 1'b1;
  logic [23:0] base = '0;
  logic [3:0] rLogIo [0:127];
  logic [3:0] rLogOe [0:127];
  logic [3:0] fLogIo [0:127];
  logic [7:0] rxBuf [0:15];
  int rc = 0, lastRc = 0, rxN = 0, winCnt = 0, gapRun = 0, minGap = 1000;
  int cyc = 0, lastRise = 0, minSp = 1000, maxSp = 0, readyBad = 0;
  logic [7:0] cmdLast = '0, cmdPrev = '0;
  logic prevSclk = 1'b0, prevCs = 1'b1;
  logic [3:0] prevIo = '0, prevOe = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      rc = 0; winCnt = 0; gapRun = 0; rxN = 0;
      prevSclk = 1'b0; prevCs = 1'b1;
    end else begin
      if (reqReady && !csN) readyBad++;
      if (rdValid && rxN < 16) begin rxBuf[rxN] = rdData; rxN++; end
      if (csN) begin
        if (!prevCs) begin
          logic [7:0] c;
          c = '0;
          for (int i = 0; i < 8; i++) c = {c[6:0], rLogIo[i][0]};
          cmdPrev = cmdLast; cmdLast = c; winCnt++; lastRc = rc;
          gapRun = 0;
        end
        gapRun++;
        if (sclk) readyBad++;
      end else begin
        if (prevCs) begin
          if (winCnt > 0 && gapRun < minGap) minGap = gapRun;
          rc = 0;
        end
        if (!prevSclk && sclk) begin
          if (rc > 0) begin
            if (cyc - lastRise < minSp) minSp = cyc - lastRise;
            if (cyc - lastRise > maxSp) maxSp = cyc - lastRise;
          end
          lastRise = cyc;
          if (rc < 128) begin rLogIo[rc] = prevIo; rLogOe[rc] = prevOe; end
          rc++;
          if (fmtMode == 2 && rc > dOf(2, fmtCmd))
            ioIn = memByte(base + 24'(rc - dOf(2, fmtCmd) - 1)) & 8'h0F;
        end
        if (prevSclk && !sclk) begin
          int d, i;
          logic [7:0] b;
          if (rc > 0 && rc <= 128) fLogIo[rc-1] = prevIo;
          d = dOf(fmtMode, fmtCmd);
          if (rc >= d) begin
            i = rc - d;
            if (fmtMode == 0) begin
              b = memByte(base + 24'(i / 8));
              ioIn = {2'b00, b[7 - (i % 8)], 1'b0};
            end else if (fmtMode == 1) begin
              b = memByte(base + 24'(i / 2));
              ioIn = (i % 2 == 0) ? b[7:4] : b[3:0];
            end else begin
              b = memByte(base + 24'(i));
              ioIn = b[7:4];
            end
          end
        end
      end
      prevIo = ioOut; prevOe = ioOe; prevSclk = sclk; prevCs = csN;
    end
  end

  task automatic runReq(input vec_t v);
    string rq;
    int off, slots;
    logic [23:0] ga;
    logic [7:0] gm, gc, ec;
    rq = (v.fmt == 0) ? "R2" : (v.fmt == 1) ? "R3" : "R4";
    while (!reqReady) @(negedge clk);
    fmtMode = int'(v.fmt); fmtCmd = v.expCmd; base = v.addr; rxN = 0;
    reqAddr = v.addr; reqCount = 16'(v.count); cfgMode = v.mode; cfgCont = v.cont;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R11", 32'(reqReady), 0);
    while (!reqReady) @(negedge clk);
    off = 0;
    if (v.expCmd) begin
      gc = '0;
      for (int i = 0; i < 8; i++) gc = {gc[6:0], rLogIo[i][0]};
      ec = (v.fmt == 0) ? 8'h03 : (v.fmt == 1) ? 8'hEB : 8'hED;
      chk(gc == ec, rq, 32'(gc), 32'(ec));
      chk(rLogOe[0] == 4'b0001, rq, 32'(rLogOe[0]), 1);
      off = 8;
    end
    ga = '0; gm = '0;
    if (v.fmt == 0) begin
      for (int i = 0; i < 24; i++) ga = {ga[22:0], rLogIo[off + i][0]};
    end else if (v.fmt == 1) begin
      for (int i = 0; i < 6; i++) ga = {ga[19:0], rLogIo[off + i]};
      gm = {rLogIo[off + 6], rLogIo[off + 7]};
      chk(rLogOe[off] == 4'hF, "R3", 32'(rLogOe[off]), 32'hF);
      chk(rLogOe[off + 8] == 4'h0, "R5", 32'(rLogOe[off + 8]), 0);
    end else begin
      for (int i = 0; i < 3; i++) ga = {ga[15:0], rLogIo[off + i], fLogIo[off + i]};
      gm = {rLogIo[off + 3], fLogIo[off + 3]};
      chk(rLogOe[off + 4] == 4'h0, "R5", 32'(rLogOe[off + 4]), 0);
    end
    chk(ga == v.addr, rq, 32'(ga), 32'(v.addr));
    if (v.fmt != 0)
      chk(gm == v.expMode, (v.expMode == 8'hA5) ? "R7" : "R8", 32'(gm), 32'(v.expMode));
    slots = (v.fmt == 0) ? 8 : (v.fmt == 1) ? 2 : 1;
    chk(lastRc == dOf(int'(v.fmt), v.expCmd) + int'(v.count) * slots, "R5", lastRc,
        dOf(int'(v.fmt), v.expCmd) + int'(v.count) * slots);
    chk(rxN == int'(v.count), "R9", rxN, int'(v.count));
    for (int i = 0; i < int'(v.count); i++)
      chk(rxBuf[i] == memByte(v.addr + 24'(i)), (v.fmt == 2) ? "R6" : "R9",
          32'(rxBuf[i]), 32'(memByte(v.addr + 24'(i))));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b0 && reqReady == 1'b0, "R1",
        {29'd0, csN, sclk, reqReady}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b0, "R1", 32'(reqReady), 0);
    while (!reqReady) @(negedge clk);
    chk(winCnt == 2, "R1", winCnt, 2);
    chk(cmdPrev == 8'hFF, "R1", 32'(cmdPrev), 32'hFF);
    chk(cmdLast == 8'hAB, "R1", 32'(cmdLast), 32'hAB);
  endtask

  initial begin
    doReset();
    for (int k = 0; k < 12; k++) runReq(VEC[k]);
    // arm, then reset: the armed state must be forgotten (R1)
    runReq('{2'd2, 1'b1, 24'h000800, 4'd2, 2'd2, 1'b1, 8'hA5});
    doReset();
    runReq('{2'd2, 1'b1, 24'h000900, 4'd2, 2'd2, 1'b1, 8'hA5});
    chk(minSp == CLK_DIV && maxSp == CLK_DIV, "R10", minSp, CLK_DIV);
    chk(minGap >= CLK_DIV, "R10", minGap, CLK_DIV);
    chk(readyBad == 0, "R11", readyBad, 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule